// File: doc/BRIEF.md
# Frame-Pulse to Pilot-Tone Rate Converter

This block turns a train of short frame pulses at a nominal 24 Hz into a square wave at a nominal 60 Hz that stays phase-locked to the frames. It runs entirely from a fast, stable system clock. Analog loop filtering is not used. Every second rising frame edge is a sync point, which is the 12 Hz instant where both rates line up. The block counts system clocks between consecutive sync points and splits that count into ten half-periods. It also forces the tone back into phase at every sync point. Five tone cycles therefore fit exactly into every two frames.

The tone follows the first measured interval at once, so a rough lock exists from the second sync point onward. A separate lock flag reports when the measured intervals have settled. When frames stop, the block drops its measurement and free-runs at a nominal rate derived from the clock-frequency parameter. It returns to tracking when frames resume. The measured interval is also made available on a port. Level shifting, motor drive and sine shaping belong outside the block.

Top module: `fp_pilot_tone`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tone_o` is 1, `locked_o` is 0 and `period_o` is 0.
- R2: Only the 0-to-1 transition of `frame_i` counts, seen through a two-stage synchronizer. The width of the frame pulse has no effect on any output.
- R3: The first rising edge after reset or after a dropout is a sync point, and so is every second edge after it. From the second sync point on, `period_o` holds the number of clocks between the last two sync points. It changes only at a sync point or at a dropout.
- R4: At every sync point `tone_o` restarts high. With the lock flag set, exactly ten tone transitions occur from one sync point to the next.
- R5: With interval N = 10q + r (0 <= r <= 9), the transitions after a sync point at clock s fall at s + k*q + floor(k*r/10) for k = 1..10. Each one therefore lies less than one clock away from the ideal s + k*N/10.
- R6: The interval measured at a sync point sets the tone rate from that same sync point onward, without waiting for the lock flag.
- R7: At a sync point that has an earlier measurement, `locked_o` becomes 1 if the new interval differs from the previous one by less than LOCK_TOL clocks, and 0 otherwise. It changes at no other time, apart from a dropout.
- R8: When a measurement exists and 2*`period_o` clocks pass after the last sync point with no new one, a dropout occurs. `locked_o` and `period_o` go to 0, the next rising edge becomes a sync point, and the tone restarts its half-period sequence at the nominal rate without changing level.
- R9: Without a measurement, the tone runs from the nominal interval CLK_HZ/12 split the same way as in R5. After reset the first transition comes (CLK_HZ/12)/10 clocks after the last reset clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Raw frame pulse, asynchronous to clk |
| tone_o | output | 1 | Pilot-tone square wave |
| locked_o | output | 1 | Measured intervals have settled |
| period_o | output | $clog2(CLK_HZ)+1 | Last measured sync interval in clocks, 0 when none |

## Verification
An input level first sampled at a clock edge e is acted on at edge e+2. A resulting change in `period_o`, `locked_o` or the tone restart is visible right after that edge. Every tone transition is visible right after the edge at which its half-period ends. The bench reference model applies those same edge numbers to the frame samples it takes. All outputs are compared on the falling clock edge, half a cycle after the registers settle. Transition counts and edge timing are measured from the sync-point clock the model records.

// File: rtl/fp_tone_pkg.sv
package fp_tone_pkg;
  // Measurement progress of the interval meter
  typedef enum logic [1:0] {
    MS_IDLE   = 2'd0,   // no sync point seen yet
    MS_PRIMED = 2'd1,   // one sync point seen, no interval yet
    MS_TRACK  = 2'd2    // at least one interval measured
  } meas_state_e;

  localparam int unsigned SPLIT = 10;  // half-periods per sync interval
endpackage

// File: rtl/fp_frame_pair.sv
module fp_frame_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_i,
  input  logic drop_i,
  output logic sync_o
);
  logic [2:0] smp_q;   // [0],[1] synchronizer, [2] previous level
  logic       odd_q;   // set after a sync edge, waiting for the partner edge
  logic       rise;

  assign rise   = smp_q[1] & ~smp_q[2];
  assign sync_o = rise & ~odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      odd_q <= 1'b0;
    end else begin
      smp_q <= {smp_q[1:0], frame_i};
      if (drop_i)    odd_q <= 1'b0;
      else if (rise) odd_q <= ~odd_q;
    end
  end
endmodule

// File: rtl/fp_interval_meter.sv
module fp_interval_meter
  import fp_tone_pkg::*;
#(
  parameter int CW       = 16,
  parameter int LOCK_TOL = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  output logic          ld_o,
  output logic [CW-1:0] ival_o,
  output logic          drop_o,
  output logic          locked_o,
  output logic [CW-1:0] period_o
);
  meas_state_e   st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] diff;
  logic [CW:0]   elapsed;
  logic [CW:0]   limit;

  assign ival_o  = cnt_q + CW'(1);
  assign ld_o    = sync_i && (st_q != MS_IDLE);
  assign elapsed = {1'b0, cnt_q} + (CW+1)'(1);
  assign limit   = {period_o, 1'b0};
  assign drop_o  = (st_q == MS_TRACK) && !sync_i && (elapsed >= limit);
  assign diff    = (ival_o > period_o) ? (ival_o - period_o) : (period_o - ival_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= MS_IDLE;
      cnt_q    <= '0;
      locked_o <= 1'b0;
      period_o <= '0;
    end else begin
      if (sync_i)            cnt_q <= '0;
      else if (~&cnt_q)      cnt_q <= cnt_q + CW'(1);

      if (sync_i) begin
        if (st_q == MS_TRACK) locked_o <= (diff < CW'(LOCK_TOL));
        if (st_q != MS_IDLE) begin
          period_o <= ival_o;
          st_q     <= MS_TRACK;
        end else begin
          st_q     <= MS_PRIMED;
        end
      end else if (drop_o) begin
        st_q     <= MS_IDLE;
        locked_o <= 1'b0;
        period_o <= '0;
      end
    end
  end
endmodule

// File: rtl/fp_tone_divider.sv
module fp_tone_divider
  import fp_tone_pkg::*;
#(
  parameter int CW    = 16,
  parameter int NOM_Q = 100,
  parameter int NOM_R = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  logic          ld_i,
  input  logic [CW-1:0] ival_i,
  input  logic          drop_i,
  output logic          tone_o
);
  localparam logic [CW-1:0] TEN = CW'(SPLIT);

  logic [CW-1:0] q_q, len_q, hc_q;
  logic [3:0]    r_q, acc_q;
  logic [CW-1:0] q_new, q_eff;
  logic [3:0]    r_new, r_eff;
  logic [4:0]    acc_sum;

  assign q_new   = ival_i / TEN;
  assign r_new   = 4'(ival_i % TEN);
  assign q_eff   = ld_i ? q_new : q_q;
  assign r_eff   = ld_i ? r_new : r_q;
  assign acc_sum = {1'b0, acc_q} + {1'b0, r_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= CW'(NOM_Q);
      r_q    <= 4'(NOM_R);
      tone_o <= 1'b1;
      hc_q   <= '0;
      len_q  <= CW'(NOM_Q);
      acc_q  <= 4'(NOM_R);
    end else begin
      if (ld_i) begin
        q_q <= q_new;
        r_q <= r_new;
      end else if (drop_i) begin
        q_q <= CW'(NOM_Q);
        r_q <= 4'(NOM_R);
      end

      if (sync_i) begin
        tone_o <= 1'b1;
        hc_q   <= '0;
        len_q  <= q_eff;
        acc_q  <= r_eff;
      end else if (drop_i) begin
        hc_q   <= '0;
        len_q  <= CW'(NOM_Q);
        acc_q  <= 4'(NOM_R);
      end else if (hc_q + CW'(1) == len_q) begin
        tone_o <= ~tone_o;
        hc_q   <= '0;
        if (acc_sum >= 5'(SPLIT)) begin
          len_q <= q_q + CW'(1);
          acc_q <= 4'(acc_sum - 5'(SPLIT));
        end else begin
          len_q <= q_q;
          acc_q <= acc_sum[3:0];
        end
      end else begin
        hc_q <= hc_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/fp_pilot_tone.sv
module fp_pilot_tone #(
  parameter int CLK_HZ   = 1_000_000,
  parameter int LOCK_TOL = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_i,
  output logic                    tone_o,
  output logic                    locked_o,
  output logic [$clog2(CLK_HZ):0] period_o
);
  localparam int CW     = $clog2(CLK_HZ) + 1;
  localparam int NOM_IV = CLK_HZ / 12;
  localparam int NOM_Q  = NOM_IV / 10;
  localparam int NOM_R  = NOM_IV % 10;

  logic          sync_pt;
  logic          drop;
  logic          ld;
  logic [CW-1:0] ival;

  fp_frame_pair u_pair (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_i (frame_i),
    .drop_i  (drop),
    .sync_o  (sync_pt)
  );

  fp_interval_meter #(.CW(CW), .LOCK_TOL(LOCK_TOL)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_i   (sync_pt),
    .ld_o     (ld),
    .ival_o   (ival),
    .drop_o   (drop),
    .locked_o (locked_o),
    .period_o (period_o)
  );

  fp_tone_divider #(.CW(CW), .NOM_Q(NOM_Q), .NOM_R(NOM_R)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (sync_pt),
    .ld_i   (ld),
    .ival_i (ival),
    .drop_i (drop),
    .tone_o (tone_o)
  );
endmodule

// File: rtl/fp_pilot_tone_chk.sv
module fp_pilot_tone_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_pt,
  input logic          drop,
  input logic          tone_o,
  input logic          locked_o,
  input logic [PW-1:0] period_o
);
  AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pt |=> tone_o);                                            // R4
  AST_LOCK_HAS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    locked_o |-> (period_o != '0));                                 // R7
  AST_LOCK_ONLY_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(sync_pt));                            // R7
  AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_pt && !drop) |=> $stable(period_o));                     // R3
  AST_DROPOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (!locked_o && period_o == '0));                        // R8
endmodule

bind fp_pilot_tone fp_pilot_tone_chk #(.PW($clog2(CLK_HZ) + 1)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sync_pt  (sync_pt),
  .drop     (drop),
  .tone_o   (tone_o),
  .locked_o (locked_o),
  .period_o (period_o)
);

// File: tb/fp_pilot_tone_tb.sv
module fp_pilot_tone_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 12345;
  localparam int TOL        = 8;
  localparam int PW         = $clog2(CLK_HZ) + 1;
  localparam int NIV        = CLK_HZ / 12;
  localparam int NQ         = NIV / 10;
  localparam int NR         = NIV % 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_i = 1'b0;
  logic          tone_o, locked_o;
  logic [PW-1:0] period_o;

  int tests = 0, fails = 0;
  string phase_req = "R9";

  fp_pilot_tone #(.CLK_HZ(CLK_HZ), .LOCK_TOL(TOL)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i),
    .tone_o(tone_o), .locked_o(locked_o), .period_o(period_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int cyc = 0;
  int x0, x1, x2, par, mst, a_cyc, meas, lck, q, r, tone, k, tnext;
  int sync_ev, locked_before;

  always @(posedge clk) begin
    int rise, sync, drop, iv;
    cyc++;
    sync_ev = 0;
    if (!rst_n) begin
      x0 = 0; x1 = 0; x2 = 0; par = 0; mst = 0; meas = 0; lck = 0;
      q = NQ; r = NR; tone = 1; k = 0; tnext = cyc + NQ; a_cyc = cyc;
    end else begin
      rise = (x1 != 0 && x2 == 0);
      sync = rise && !par;
      drop = (mst == 2) && !sync && (cyc - a_cyc >= 2*meas);
      if (drop) par = 0; else if (rise) par = !par;
      if (sync) begin
        locked_before = lck;
        if (mst != 0) begin
          iv = cyc - a_cyc;
          if (mst == 2) lck = ((iv > meas ? iv - meas : meas - iv) < TOL);
          meas = iv; mst = 2; q = iv / 10; r = iv % 10;
        end else mst = 1;
        a_cyc = cyc; tone = 1; k = 0; tnext = cyc + q;
        sync_ev = 1;
      end else if (drop) begin
        mst = 0; lck = 0; meas = 0; q = NQ; r = NR; k = 0; tnext = cyc + NQ;
      end else if (cyc == tnext) begin
        tone = !tone;
        k = (k + 1) % 10;
        tnext = cyc + q + (((k+1)*r)/10 - (k*r)/10);
      end
      x2 = x1; x1 = x0;
    end
    x0 = frame_i;
  end

  // ---------------- per-cycle comparison ----------------
  int prev_tone = 1, toggles = 0, m_idx = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check({phase_req, " tone"},   tone_o,   tone);
      check("R7 lock",              locked_o, lck);
      check("R3 period",            period_o, meas);
      if (tone_o != prev_tone) begin
        toggles++;
        if (!sync_ev) m_idx++;
        // R5: each transition within one clock of the ideal split
        if (mst == 2 && !sync_ev && m_idx <= 10) begin
          tests++;
          if (((cyc - a_cyc)*10 - m_idx*meas) >= 10 || ((cyc - a_cyc)*10 - m_idx*meas) <= -10) begin
            fails++;
            $display("FAIL R5 actual=%0d expected~=%0d/10", cyc - a_cyc, m_idx*meas);
          end
        end
      end
      if (sync_ev) begin
        if (locked_before && mst == 2) check("R4 transitions per interval", toggles, 10);
        toggles = 0;
        m_idx = 0;
      end
    end
    prev_tone = tone_o;
  end

  task automatic frames(input int per, input int wid, input int n);
    for (int i = 0; i < n; i++) begin
      frame_i = 1'b1;
      repeat (wid) @(negedge clk);
      frame_i = 1'b0;
      repeat (per - wid) @(negedge clk);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int j;
    repeat (4) @(negedge clk);
    check("R1 tone in reset", tone_o, 1);
    check("R1 lock in reset", locked_o, 0);
    check("R1 period in reset", period_o, 0);
    rst_n = 1'b1;
    j = 0;
    do begin @(negedge clk); j++; end while (tone_o == 1'b1 && j < 10*NQ);
    check("R9 first nominal transition", j, NQ);
    repeat (1200) @(negedge clk);

    phase_req = "R6";
    frames(514, 60, 10);
    repeat (20) @(negedge clk);
    check("R3 measured interval", period_o, 1028);
    check("R7 lock after steady input", locked_o, 1);

    phase_req = "R2";
    frames(530, 200, 10);
    repeat (20) @(negedge clk);
    check("R2 wide pulses interval", period_o, 1060);
    check("R7 relock at new rate", locked_o, 1);

    phase_req = "R5";
    frames(499, 2, 10);
    repeat (20) @(negedge clk);
    check("R2 narrow pulses interval", period_o, 998);

    phase_req = "R9";
    repeat (2500) @(negedge clk);
    check("R8 lock cleared on dropout", locked_o, 0);
    check("R8 period cleared on dropout", period_o, 0);

    phase_req = "R6";
    frames(514, 60, 6);
    repeat (20) @(negedge clk);
    check("R7 lock after resume", locked_o, 1);
    check("R3 interval after resume", period_o, 1028);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule